// File: doc/BRIEF.md
# Store-Conditional Retry Throttle

This block sits between a pending atomic operation and the memory port of a data cache. It issues the atomic toward memory with a request/acknowledge handshake, waits for the atomic response, and inspects that response when the operation was a store-conditional. A failed store-conditional opens a randomized waiting window that doubles in width with every further failure. A successful one closes the window. While the window's countdown is running, a new store-conditional is held back, so that cores contending for one reservation stop colliding in lock step.

The window is a bit mask that gains one low-order bit per failure, up to a parameterized cap. On a failure the countdown is loaded with a pseudo-random value from a free-running linear feedback shift register, masked by the widened window. The countdown then falls by one each clock. Every other atomic kind is issued at once, whatever the countdown holds.

Top module: `sc_backoff_gate`

## Requirements
- R1: After reset the window is empty, the countdown is zero and the block is in its request phase, so `wait_rsp` is low and the first store-conditional (opcode value 4'h3 on `amo_op`) drives `mem_req` high in the same cycle that `amo_valid` rises.
- R2: A store-conditional response counts as a failure when `rsp_valid` is high in the wait phase for an issued store-conditional and `rsp_result` is non-zero. The window mask then becomes (mask << 1) | 1, and the countdown is loaded with the generator value ANDed with that new mask, both at the response edge.
- R3: A store-conditional response with `rsp_result` equal to zero counts as a success. It clears the window mask and the countdown, so the next store-conditional is issued without delay.
- R4: While `amo_valid` is high with the store-conditional opcode, `mem_req` stays low for exactly as many cycles as the countdown held after the response edge. The countdown falls by one per clock and holds at zero.
- R5: Any opcode other than 4'h3 drives `mem_req` high in the first cycle that `amo_valid` is high in the request phase. Its response leaves the window and the countdown unchanged.
- R6: The block enters the wait phase (`wait_rsp` high) only at an edge where `mem_req` and `mem_ack` are both high. It returns to the request phase at the edge where `rsp_valid` is high. A `rsp_valid` pulse in the request phase is ignored.
- R7: The window mask saturates at MAX_EXP ones (default 16). Further failures keep it at that width.
- R8: The generator is a 16-bit Fibonacci register with feedback q[15]^q[13]^q[12]^q[10] shifted into bit 0. It holds 3 at reset, steps on every clock after reset and never reaches zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| amo_valid | input | 1 | An atomic operation is pending, held until accepted |
| amo_op | input | 4 | Atomic opcode; 4'h3 marks a store-conditional |
| mem_req | output | 1 | Atomic request toward memory |
| mem_ack | input | 1 | Memory accepts the request while `mem_req` is high |
| wait_rsp | output | 1 | High while the issued atomic awaits its response |
| rsp_valid | input | 1 | Atomic response arrives |
| rsp_result | input | RES_W (64) | Result word; for a store-conditional, zero means success |

## Verification
The bench runs its own model of the 16-bit generator from reset and predicts the exact cycle in which each held-back store-conditional is released. A wrong tap, seed or mask width therefore shows up as a release that comes early or late. A run of failures past the cap shows whether the window stops at MAX_EXP bits; a window that wraps or keeps growing releases at the wrong cycle. An add issued during a live countdown must go out at once, and its non-zero result must leave the pending delay as it was. A stalled acknowledgement and a stray response in the request phase show whether the phase changes only on a real handshake.

// File: rtl/sc_backoff_pkg.sv
package sc_backoff_pkg;

   localparam int OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      AOP_SWAP = 4'h0,
      AOP_ADD  = 4'h1,
      AOP_LR   = 4'h2,
      AOP_SC   = 4'h3,
      AOP_AND  = 4'h4,
      AOP_OR   = 4'h5
   } aop_e;

   typedef enum logic {
      PH_REQ  = 1'b0,
      PH_WAIT = 1'b1
   } phase_e;

endpackage

// File: rtl/backoff_lfsr.sv
module backoff_lfsr #(
   parameter int          W    = 16,
   parameter logic [63:0] SEED = 64'd3
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] value
);

   logic [W-1:0] q;
   logic         fb;

   generate
      if (W == 8) begin : g_w8
         assign fb = q[7] ^ q[5] ^ q[4] ^ q[3];
      end else if (W == 16) begin : g_w16
         assign fb = q[15] ^ q[13] ^ q[12] ^ q[10];
      end else if (W == 32) begin : g_w32
         assign fb = q[31] ^ q[21] ^ q[1] ^ q[0];
      end else begin : g_bad
         $error("backoff_lfsr: width %0d has no tap set", W);
         assign fb = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= SEED[W-1:0];
      else        q <= {q[W-2:0], fb};
   end

   assign value = q;

endmodule

// File: rtl/backoff_window.sv
module backoff_window #(
   parameter int MAX_EXP = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               grow,
   input  logic               reset_win,
   input  logic [MAX_EXP-1:0] rnd,
   output logic [MAX_EXP-1:0] mask,
   output logic [MAX_EXP-1:0] cnt,
   output logic               expired
);

   logic [MAX_EXP-1:0] mask_q, cnt_q, mask_next;

   // one more low bit per failure; an all-ones mask stays all-ones
   assign mask_next = {mask_q[MAX_EXP-2:0], 1'b1};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         cnt_q  <= '0;
      end else if (reset_win) begin       // success has priority
         mask_q <= '0;
         cnt_q  <= '0;
      end else if (grow) begin
         mask_q <= mask_next;
         cnt_q  <= rnd & mask_next;
      end else if (cnt_q != '0) begin
         cnt_q  <= cnt_q - 1'b1;
      end
   end

   assign mask    = mask_q;
   assign cnt     = cnt_q;
   assign expired = (cnt_q == '0);

endmodule

// File: rtl/sc_issue_ctrl.sv
module sc_issue_ctrl
   import sc_backoff_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            amo_valid,
   input  logic [OP_W-1:0] amo_op,
   input  logic            sc_allowed,
   input  logic            mem_ack,
   input  logic            rsp_valid,
   output logic            mem_req,
   output logic            waiting,
   output logic            issued_sc
);

   phase_e ph_q;
   logic   is_sc, sc_q;

   assign is_sc   = (amo_op == AOP_SC);
   assign mem_req = (ph_q == PH_REQ) && amo_valid && (!is_sc || sc_allowed);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q <= PH_REQ;
         sc_q <= 1'b0;
      end else begin
         unique case (ph_q)
            PH_REQ: if (mem_req && mem_ack) begin
               ph_q <= PH_WAIT;
               sc_q <= is_sc;
            end
            PH_WAIT: if (rsp_valid) ph_q <= PH_REQ;
            default: ph_q <= PH_REQ;
         endcase
      end
   end

   assign waiting   = (ph_q == PH_WAIT);
   assign issued_sc = sc_q;

endmodule

// File: rtl/sc_backoff_gate.sv
module sc_backoff_gate
   import sc_backoff_pkg::*;
#(
   parameter int          LFSR_W  = 16,
   parameter logic [63:0] SEED    = 64'd3,
   parameter int          MAX_EXP = 16,
   parameter int          RES_W   = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             amo_valid,
   input  logic [3:0]       amo_op,
   output logic             mem_req,
   input  logic             mem_ack,
   output logic             wait_rsp,
   input  logic             rsp_valid,
   input  logic [RES_W-1:0] rsp_result
);

   if (MAX_EXP < 2 || MAX_EXP > LFSR_W) begin : g_chk_exp
      $error("sc_backoff_gate: MAX_EXP must lie in 2..LFSR_W");
   end
   if (RES_W < 1) begin : g_chk_res
      $error("sc_backoff_gate: RES_W must be positive");
   end

   logic [LFSR_W-1:0]  lfsr_q;
   logic [MAX_EXP-1:0] bo_mask, bo_cnt;
   logic               bo_zero, bo_set, bo_clr, issued_sc, rsp_fire;

   backoff_lfsr #(.W(LFSR_W), .SEED(SEED)) u_lfsr (
      .clk   (clk),
      .rst_n (rst_n),
      .value (lfsr_q)
   );

   sc_issue_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .amo_valid  (amo_valid),
      .amo_op     (amo_op),
      .sc_allowed (bo_zero),
      .mem_ack    (mem_ack),
      .rsp_valid  (rsp_valid),
      .mem_req    (mem_req),
      .waiting    (wait_rsp),
      .issued_sc  (issued_sc)
   );

   assign rsp_fire = wait_rsp && rsp_valid && issued_sc;
   assign bo_set   = rsp_fire && (rsp_result != '0);
   assign bo_clr   = rsp_fire && (rsp_result == '0);

   backoff_window #(.MAX_EXP(MAX_EXP)) u_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .grow      (bo_set),
      .reset_win (bo_clr),
      .rnd       (lfsr_q[MAX_EXP-1:0]),
      .mask      (bo_mask),
      .cnt       (bo_cnt),
      .expired   (bo_zero)
   );

endmodule

// File: rtl/sc_backoff_chk.sv
module sc_backoff_chk #(
   parameter int LFSR_W  = 16,
   parameter int MAX_EXP = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               amo_valid,
   input logic [3:0]         amo_op,
   input logic               mem_req,
   input logic               mem_ack,
   input logic               wait_rsp,
   input logic               set_p,
   input logic               clr_p,
   input logic [MAX_EXP-1:0] mask,
   input logic [MAX_EXP-1:0] cnt,
   input logic [LFSR_W-1:0]  lfsr
);

   p_grow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      set_p && !clr_p |=> mask == {$past(mask[MAX_EXP-2:0]), 1'b1});

   p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      set_p && !clr_p |=> cnt == ($past(lfsr[MAX_EXP-1:0]) & mask));

   p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      clr_p |=> (mask == '0) && (cnt == '0));

   p_sc_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && (amo_op == 4'h3) |-> cnt == '0);

   p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !set_p && !clr_p && (cnt != '0) |=> cnt == $past(cnt) - 1'b1);

   p_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !wait_rsp && amo_valid && (amo_op != 4'h3) |-> mem_req);

   p_enter_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wait_rsp) |-> $past(mem_req && mem_ack));

   p_no_req_waiting_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wait_rsp |-> !mem_req);

   p_pulse_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(set_p && clr_p));

   p_lfsr_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
      lfsr != '0);

endmodule

bind sc_backoff_gate sc_backoff_chk #(.LFSR_W(LFSR_W), .MAX_EXP(MAX_EXP)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .amo_valid (amo_valid),
   .amo_op    (amo_op),
   .mem_req   (mem_req),
   .mem_ack   (mem_ack),
   .wait_rsp  (wait_rsp),
   .set_p     (bo_set),
   .clr_p     (bo_clr),
   .mask      (bo_mask),
   .cnt       (bo_cnt),
   .lfsr      (lfsr_q)
);

// File: tb/tb_sc_backoff_gate.sv
module tb_sc_backoff_gate;

   localparam int CLK_PERIOD = 10;
   localparam int CAP_EXP    = 6;
   localparam int RES_W      = 64;
   localparam logic [3:0] OP_SC  = 4'h3;
   localparam logic [3:0] OP_ADD = 4'h1;
   localparam logic [3:0] OP_OR  = 4'h5;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             amo_valid = 1'b0;
   logic [3:0]       amo_op = 4'h0;
   logic             mem_req;
   logic             mem_ack = 1'b0;
   logic             wait_rsp;
   logic             rsp_valid = 1'b0;
   logic [RES_W-1:0] rsp_result = '0;

   int checks = 0;
   int errors = 0;

   // bench-side reference: cycle counter and generator sequence (R8)
   longint      cyc = 0;
   logic [15:0] gen_m;
   logic [CAP_EXP-1:0] mask_m = '0;
   longint      ready_at = 0;

   sc_backoff_gate #(.MAX_EXP(CAP_EXP), .RES_W(RES_W)) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .amo_valid  (amo_valid),
      .amo_op     (amo_op),
      .mem_req    (mem_req),
      .mem_ack    (mem_ack),
      .wait_rsp   (wait_rsp),
      .rsp_valid  (rsp_valid),
      .rsp_result (rsp_result)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (!rst_n) gen_m <= 16'd3;
      else        gen_m <= {gen_m[14:0], gen_m[15] ^ gen_m[13] ^ gen_m[12] ^ gen_m[10]};
   end

   task automatic check(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Issue one atomic, check gating per cycle, stall the ack, then respond.
   task automatic run_op(input string req, input logic [3:0] op,
                         input logic [RES_W-1:0] res, input int ack_stall);
      bit     bad = 1'b0;
      longint bad_act = 0, bad_exp = 0;
      amo_op    = op;
      amo_valid = 1'b1;
      #1;
      for (int i = 0; i < 200; i++) begin
         logic exp_req;
         exp_req = (op != OP_SC) || (cyc >= ready_at);
         if (mem_req !== exp_req && !bad) begin
            bad = 1'b1; bad_act = mem_req; bad_exp = exp_req;
         end
         if (mem_req) break;
         @(negedge clk); #1;
      end
      checks++;
      if (bad || !mem_req) begin
         errors++;
         $display("FAIL %s: release cycle wrong, mem_req actual %0d expected %0d (cycle %0d, ready %0d)",
                  req, bad_act, bad_exp, cyc, ready_at);
      end
      for (int s = 0; s < ack_stall; s++) begin
         @(negedge clk); #1;
         check("R6 stalled ack keeps request phase", wait_rsp, 0);
         check("R6 request held during stall", mem_req, 1);
      end
      mem_ack = 1'b1;
      @(negedge clk);
      mem_ack   = 1'b0;
      amo_valid = 1'b0;
      #1;
      check({req, " / R6 wait phase after ack"}, wait_rsp, 1);
      rsp_valid  = 1'b1;
      rsp_result = res;
      if (op == OP_SC) begin
         if (res != '0) begin
            mask_m   = {mask_m[CAP_EXP-2:0], 1'b1};
            ready_at = cyc + 1 + longint'(gen_m[CAP_EXP-1:0] & mask_m);
         end else begin
            mask_m   = '0;
            ready_at = cyc + 1;
         end
      end
      @(negedge clk);
      rsp_valid  = 1'b0;
      rsp_result = '0;
      #1;
      check({req, " / R6 back to request phase"}, wait_rsp, 0);
   endtask

   task automatic t_reset();
      check("R1 reset mem_req low when idle", mem_req, 0);
      check("R1 reset wait_rsp low", wait_rsp, 0);
   endtask

   task automatic t_first_sc();
      run_op("R1 first SC not delayed; R3 success", OP_SC, '0, 0);
   endtask

   task automatic t_fail_run();
      for (int k = 0; k < CAP_EXP + 3; k++)
         run_op("R2 R4 R7 R8 failure window", OP_SC, 64'd1 << k, 0);
   endtask

   task automatic t_bypass();
      run_op("R2 failure before bypass", OP_SC, 64'hFF, 0);
      run_op("R5 add issued during countdown", OP_ADD, 64'h55, 0);
      run_op("R5 or issued during countdown", OP_OR, 64'h1, 1);
      run_op("R5 SC release unchanged by other atomics", OP_SC, 64'h2, 0);
   endtask

   task automatic t_success_resets();
      run_op("R3 pending SC then success", OP_SC, '0, 0);
      check("R3 window cleared in model", mask_m, 0);
      run_op("R3 SC right after success", OP_SC, 64'h4, 0);
      run_op("R3 window restarts at one bit", OP_SC, '0, 0);
   endtask

   task automatic t_stray_rsp();
      run_op("R2 failure before stray", OP_SC, 64'h9, 2);
      rsp_valid  = 1'b1;
      rsp_result = '0;
      @(negedge clk);
      rsp_valid = 1'b0;
      #1;
      check("R6 stray response ignored", wait_rsp, 0);
      run_op("R6 stray response left countdown", OP_SC, '0, 0);
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            t_reset();
            rst_n = 1'b1;
            @(negedge clk);
            t_reset();
            t_first_sc();
            t_fail_run();
            t_bypass();
            t_success_resets();
            t_stray_rsp();
         end
         begin
            repeat (50000) @(posedge clk);
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule